// File: doc/BRIEF.md
# Bit-addressable banked data memory

This block is the internal data store of a small 8-bit controller core. It holds 256 byte locations. The lower half is general storage. The upper half holds only a fixed set of special-function register locations, and these are kept as plain storage with no peripheral behaviour behind them. Three access paths share the array.

The byte path reads and writes any location by its direct address. The register path takes a register number from 0 to 7 and turns it into a byte address inside one of four eight-byte banks at the bottom of memory. The bank is picked by two bits of the status byte.

The bit path takes an 8-bit bit address and folds it onto a containing byte. Bit addresses below 80H land in the bytes from 20H to 2FH. Bit addresses from 80H upward land in special-function registers whose byte address ends in three zero bits. The bit path can read the bit, or set, clear or invert it as one read-modify-write of that byte within a single cycle.

The surrounding core drives all three paths at once. Reads are combinational. Writes are committed on the clock edge.

Top module: `bitmem_core`

## Requirements
- R1: A synchronous active-high reset clears every location to 00H, so after reset all byte reads return 00H and bank_sel is 0.
- R2: A byte write stores byte_wr_data at byte_addr on the rising edge, for addresses 00H to 7FH and for defined special-function addresses. byte_rd_data shows the current content at byte_addr combinationally.
- R3: The defined special-function addresses are 80H, 81H, 82H, 83H, 87H, 88H, 89H, 8AH, 8BH, 8CH, 8DH, 90H, 98H, 99H, A0H, A8H, B0H, B8H, D0H, E0H and F0H. Any other address from 80H to FFH reads 00H, and writes to it are ignored.
- R4: The register port maps register n of bank b to byte address 8*b+n. The bank b is bits 4:3 of the byte at D0H, and bank_sel shows it. reg_rd_data shows that byte, and a register write stores reg_wr_data there.
- R5: A bit address below 80H selects bit ba[2:0] of byte 20H+ba[6:3]. For example, 2BH is bit 3 of byte 25H.
- R6: A bit address of 80H or above selects bit ba[2:0] of byte {ba[7:3],000}. For example, F7H is bit 7 of byte F0H, and bit address E0H is only bit 0 of byte E0H.
- R7: The bit_op encoding is 0 for no change, 1 for set, 2 for clear and 3 for invert. The operation changes only the addressed bit on the rising edge. bit_rd_data shows the addressed bit combinationally.
- R8: A bit address of 80H or above whose containing byte is not a defined special-function address is rejected. bit_rd_data reads 0 and the bit operation is dropped.
- R9: When several paths write the same byte in one cycle, the byte path wins over the register path, and the register path wins over the bit path. Writes to different bytes in the same cycle all take effect.
- R10: A register write uses the bank in effect before the edge, even when the same cycle's byte write changes the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| byte_addr | input | 8 | Direct byte address for read and write |
| byte_wr_en | input | 1 | Byte write enable |
| byte_wr_data | input | 8 | Byte write data |
| byte_rd_data | output | 8 | Content at byte_addr |
| reg_num | input | 3 | Register number 0 to 7 |
| reg_wr_en | input | 1 | Register write enable |
| reg_wr_data | input | 8 | Register write data |
| reg_rd_data | output | 8 | Content of the selected register |
| bank_sel | output | 2 | Active register bank |
| bit_addr | input | 8 | Bit address |
| bit_op | input | 2 | Bit operation: 0 none, 1 set, 2 clear, 3 invert |
| bit_rd_data | output | 1 | Value of the addressed bit |

## Verification
The bench sets single bits in the bit area and in special-function registers, then reads the whole byte back. A fold that uses the wrong address bits would move the change into a neighbouring byte or the wrong bit position, and a plain write in place of a read-modify-write would wipe the other seven bits. It drives a byte write and a bit write at the same byte in one cycle, and a byte write and a register write at the same byte in one cycle. Wrong priority there would leave the bit-modified or register value in place of the byte value. It also changes the bank in the same cycle as a register write, where a design that took the new bank would write into bank 1. Finally, it aims bit operations and byte writes at undefined special-function addresses, where a design without the check would return stored data instead of zero.

// File: rtl/bitmem_pkg.sv
package bitmem_pkg;
    parameter int ADDR_W = 8;
    parameter int DATA_W = 8;
    parameter int REG_W  = 3;
    parameter int BANK_W = 2;
    localparam int DEPTH     = 1 << ADDR_W;
    localparam int IDX_W     = $clog2(DATA_W);
    localparam int BANK_LSB  = 3;
    localparam logic [ADDR_W-1:0] PSW_ADDR = 8'hD0;
    localparam logic [ADDR_W-1:0] BIT_AREA = 8'h20;

    typedef enum logic [1:0] {
        BOP_NONE = 2'd0,
        BOP_SET  = 2'd1,
        BOP_CLR  = 2'd2,
        BOP_TGL  = 2'd3
    } bit_op_e;

    typedef struct packed {
        logic              ok;
        logic [ADDR_W-1:0] byte_addr;
        logic [IDX_W-1:0]  idx;
    } bit_loc_t;

    function automatic logic sfr_defined(input logic [ADDR_W-1:0] a);
        case (a)
            8'h80, 8'h81, 8'h82, 8'h83, 8'h87, 8'h88, 8'h89, 8'h8A,
            8'h8B, 8'h8C, 8'h8D, 8'h90, 8'h98, 8'h99, 8'hA0, 8'hA8,
            8'hB0, 8'hB8, 8'hD0, 8'hE0, 8'hF0: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic addr_live(input logic [ADDR_W-1:0] a);
        return !a[ADDR_W-1] || sfr_defined(a);
    endfunction

    function automatic bit_loc_t locate_bit(input logic [ADDR_W-1:0] ba);
        bit_loc_t l;
        l.idx = ba[IDX_W-1:0];
        if (!ba[ADDR_W-1]) begin
            l.byte_addr = BIT_AREA + ADDR_W'(ba[ADDR_W-2:IDX_W]);
            l.ok        = 1'b1;
        end else begin
            l.byte_addr = {ba[ADDR_W-1:IDX_W], {IDX_W{1'b0}}};
            l.ok        = sfr_defined(l.byte_addr);
        end
        return l;
    endfunction

    function automatic logic bit_addr_ok(input logic [ADDR_W-1:0] ba);
        return !ba[ADDR_W-1] || sfr_defined({ba[ADDR_W-1:IDX_W], {IDX_W{1'b0}}});
    endfunction
endpackage

// File: rtl/bitmem_regmap.sv
module bitmem_regmap
    import bitmem_pkg::*;
(
    input  logic [BANK_W-1:0] bank,
    input  logic [REG_W-1:0]  num,
    output logic [ADDR_W-1:0] addr
);
    localparam int PAD_W = ADDR_W - BANK_W - REG_W;

    always_comb addr = {{PAD_W{1'b0}}, bank, num};
endmodule

// File: rtl/bitmem_bitunit.sv
module bitmem_bitunit
    import bitmem_pkg::*;
(
    input  logic [ADDR_W-1:0] bit_addr,
    input  logic [1:0]        op_raw,
    input  logic [DATA_W-1:0] cur_byte,
    output logic [ADDR_W-1:0] byte_addr,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              rd_bit
);
    bit_loc_t loc;
    bit_op_e  op;
    logic [DATA_W-1:0] mask;

    always_comb begin
        loc       = locate_bit(bit_addr);
        op        = bit_op_e'(op_raw);
        byte_addr = loc.byte_addr;
        mask      = DATA_W'(1) << loc.idx;
        rd_bit    = loc.ok & cur_byte[loc.idx];
        wr_en     = loc.ok && (op != BOP_NONE);
        case (op)
            BOP_SET: wr_data = cur_byte | mask;
            BOP_CLR: wr_data = cur_byte & ~mask;
            BOP_TGL: wr_data = cur_byte ^ mask;
            default: wr_data = cur_byte;
        endcase
    end
endmodule

// File: rtl/bitmem_store.sv
module bitmem_store
    import bitmem_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] byte_addr,
    input  logic              byte_we,
    input  logic [DATA_W-1:0] byte_wdata,
    output logic [DATA_W-1:0] byte_rdata,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [ADDR_W-1:0] bit_byte_addr,
    input  logic              bit_we,
    input  logic [DATA_W-1:0] bit_wdata,
    output logic [DATA_W-1:0] bit_rdata,
    output logic [BANK_W-1:0] bank
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Later statements override earlier ones: bit, then register, then byte.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (bit_we) mem[bit_byte_addr] <= bit_wdata;
            if (reg_we) mem[reg_addr] <= reg_wdata;
            if (byte_we && addr_live(byte_addr)) mem[byte_addr] <= byte_wdata;
        end
    end

    always_comb begin
        byte_rdata = addr_live(byte_addr) ? mem[byte_addr] : '0;
        reg_rdata  = mem[reg_addr];
        bit_rdata  = mem[bit_byte_addr];
        bank       = mem[PSW_ADDR][BANK_LSB +: BANK_W];
    end
endmodule

// File: rtl/bitmem_core.sv
module bitmem_core
    import bitmem_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] byte_addr,
    input  logic              byte_wr_en,
    input  logic [DATA_W-1:0] byte_wr_data,
    output logic [DATA_W-1:0] byte_rd_data,
    input  logic [REG_W-1:0]  reg_num,
    input  logic              reg_wr_en,
    input  logic [DATA_W-1:0] reg_wr_data,
    output logic [DATA_W-1:0] reg_rd_data,
    output logic [BANK_W-1:0] bank_sel,
    input  logic [ADDR_W-1:0] bit_addr,
    input  logic [1:0]        bit_op,
    output logic              bit_rd_data
);
    logic [ADDR_W-1:0] reg_addr;
    logic [ADDR_W-1:0] bit_byte_addr;
    logic [DATA_W-1:0] bit_cur;
    logic [DATA_W-1:0] bit_wdata;
    logic              bit_we;

    bitmem_regmap u_regmap (
        .bank (bank_sel),
        .num  (reg_num),
        .addr (reg_addr)
    );

    bitmem_bitunit u_bitunit (
        .bit_addr  (bit_addr),
        .op_raw    (bit_op),
        .cur_byte  (bit_cur),
        .byte_addr (bit_byte_addr),
        .wr_en     (bit_we),
        .wr_data   (bit_wdata),
        .rd_bit    (bit_rd_data)
    );

    bitmem_store u_store (
        .clk           (clk),
        .rst           (rst),
        .byte_addr     (byte_addr),
        .byte_we       (byte_wr_en),
        .byte_wdata    (byte_wr_data),
        .byte_rdata    (byte_rd_data),
        .reg_addr      (reg_addr),
        .reg_we        (reg_wr_en),
        .reg_wdata     (reg_wr_data),
        .reg_rdata     (reg_rd_data),
        .bit_byte_addr (bit_byte_addr),
        .bit_we        (bit_we),
        .bit_wdata     (bit_wdata),
        .bit_rdata     (bit_cur),
        .bank          (bank_sel)
    );
endmodule

// File: rtl/bitmem_checker.sv
module bitmem_checker
    import bitmem_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] byte_addr,
    input logic              byte_wr_en,
    input logic [DATA_W-1:0] byte_wr_data,
    input logic [DATA_W-1:0] byte_rd_data,
    input logic              reg_wr_en,
    input logic [BANK_W-1:0] bank_sel,
    input logic [ADDR_W-1:0] bit_addr,
    input logic [1:0]        bit_op,
    input logic              bit_rd_data
);
    // R1: the cycle after reset, every read comes back zero
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (byte_rd_data == '0 && bank_sel == '0));

    // R2: a byte write to a live address is read back the next cycle
    a_r2_byte_readback: assert property (@(posedge clk) disable iff (rst)
        (byte_wr_en && addr_live(byte_addr)) |=>
            ($stable(byte_addr) -> byte_rd_data == $past(byte_wr_data)));

    // R3: an undefined special-function address never reads nonzero
    a_r3_undef_zero: assert property (@(posedge clk) disable iff (rst)
        (byte_addr[ADDR_W-1] && !sfr_defined(byte_addr)) |-> byte_rd_data == '0);

    // R7: set leaves the bit at 1, clear leaves it at 0, when no other path writes
    a_r7_set_sticks: assert property (@(posedge clk) disable iff (rst)
        (bit_op == 2'd1 && !byte_wr_en && !reg_wr_en && bit_addr_ok(bit_addr)) |=>
            ($stable(bit_addr) -> bit_rd_data));

    a_r7_clear_sticks: assert property (@(posedge clk) disable iff (rst)
        (bit_op == 2'd2 && !byte_wr_en && !reg_wr_en && bit_addr_ok(bit_addr)) |=>
            ($stable(bit_addr) -> !bit_rd_data));

    // R8: a rejected bit address reads 0
    a_r8_rejected_zero: assert property (@(posedge clk) disable iff (rst)
        !bit_addr_ok(bit_addr) |-> !bit_rd_data);
endmodule

bind bitmem_core bitmem_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .byte_addr    (byte_addr),
    .byte_wr_en   (byte_wr_en),
    .byte_wr_data (byte_wr_data),
    .byte_rd_data (byte_rd_data),
    .reg_wr_en    (reg_wr_en),
    .bank_sel     (bank_sel),
    .bit_addr     (bit_addr),
    .bit_op       (bit_op),
    .bit_rd_data  (bit_rd_data)
);

// File: tb/bitmem_core_bench.sv
`timescale 1ns/1ps
module bitmem_core_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] byte_addr, byte_wr_data, reg_wr_data, bit_addr;
    logic       byte_wr_en, reg_wr_en;
    logic [2:0] reg_num;
    logic [1:0] bit_op;
    logic [7:0] byte_rd_data, reg_rd_data;
    logic [1:0] bank_sel;
    logic       bit_rd_data;
    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    bitmem_core u_bitmem_core (.*);

    // {address, write data, expected read-back}
    localparam logic [23:0] VEC [8] = '{
        {8'h00, 8'h11, 8'h11}, {8'h7F, 8'hA5, 8'hA5},
        {8'h80, 8'h3C, 8'h3C}, {8'hF0, 8'h5A, 8'h5A},
        {8'hC0, 8'h77, 8'h00}, {8'hFF, 8'h12, 8'h00},
        {8'hE0, 8'hC3, 8'hC3}, {8'h8D, 8'h69, 8'h69}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        byte_wr_en = 0; reg_wr_en = 0; bit_op = 2'd0;
        #0.5;
    endtask

    task automatic wbyte(input logic [7:0] a, input logic [7:0] d);
        byte_addr = a; byte_wr_data = d; byte_wr_en = 1; tick();
    endtask

    task automatic bitop(input logic [7:0] ba, input logic [1:0] op);
        bit_addr = ba; bit_op = op; tick();
    endtask

    task automatic rbyte(input string tag, input logic [7:0] a, input logic [7:0] exp);
        byte_addr = a; #0.5; chk(tag, byte_rd_data, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1; byte_addr = 0; byte_wr_en = 0; byte_wr_data = 0;
        reg_num = 0; reg_wr_en = 0; reg_wr_data = 0; bit_addr = 0; bit_op = 0;
        repeat (3) @(posedge clk);
        #1 rst = 0; #0.5;

        // R1 reset state
        rbyte("R1 byte 00", 8'h00, 8'h00);
        rbyte("R1 byte D0", 8'hD0, 8'h00);
        chk("R1 bank", {6'b0, bank_sel}, 8'h00);

        // R2 / R3 vector walk
        foreach (VEC[i]) begin
            wbyte(VEC[i][23:16], VEC[i][15:8]);
            rbyte(VEC[i][7:0] == VEC[i][15:8] ? "R2 byte rw" : "R3 undef", VEC[i][23:16], VEC[i][7:0]);
        end

        // R4 bank mapping
        wbyte(8'h1D, 8'h9E);
        wbyte(8'h18, 8'h44);
        wbyte(8'hD0, 8'h18);
        chk("R4 bank3", {6'b0, bank_sel}, 8'h03);
        reg_num = 3'd5; #0.5; chk("R4 R5 bank3", reg_rd_data, 8'h9E);
        reg_num = 3'd0; #0.5; chk("R4 R0 bank3", reg_rd_data, 8'h44);
        reg_num = 3'd2; reg_wr_data = 8'h5C; reg_wr_en = 1; tick();
        rbyte("R4 reg write 1A", 8'h1A, 8'h5C);
        wbyte(8'hD0, 8'h00);
        reg_num = 3'd0; #0.5; chk("R4 R0 bank0", reg_rd_data, 8'h11);

        // R5 / R7 low bit area
        wbyte(8'h25, 8'h00);
        bitop(8'h2B, 2'd1);
        rbyte("R5 set 2B", 8'h25, 8'h08);
        chk("R7 rd 2B", {7'b0, bit_rd_data}, 8'h01);
        bitop(8'h28, 2'd3);
        rbyte("R7 invert 28", 8'h25, 8'h09);
        bitop(8'h2B, 2'd2);
        rbyte("R7 clear 2B", 8'h25, 8'h01);
        bitop(8'h7F, 2'd1);
        rbyte("R5 bit 7F", 8'h2F, 8'h80);

        // R6 special-function bits
        wbyte(8'hF0, 8'h00);
        bitop(8'hF7, 2'd1);
        rbyte("R6 F7", 8'hF0, 8'h80);
        wbyte(8'hE0, 8'hFF);
        bitop(8'hE0, 2'd2);
        rbyte("R6 E0 bit0", 8'hE0, 8'hFE);
        bitop(8'h93, 2'd1);
        rbyte("R6 93", 8'h90, 8'h08);

        // R8 rejected bit address
        bitop(8'hCA, 2'd1);
        bit_addr = 8'hCA; #0.5;
        chk("R8 rd CA", {7'b0, bit_rd_data}, 8'h00);
        rbyte("R8 byte C8", 8'hC8, 8'h00);
        rbyte("R8 byte 29", 8'h29, 8'h00);

        // R9 priority
        byte_addr = 8'h25; byte_wr_data = 8'hF0; byte_wr_en = 1;
        bit_addr = 8'h28; bit_op = 2'd1; tick();
        rbyte("R9 byte over bit", 8'h25, 8'hF0);
        reg_num = 3'd3; reg_wr_data = 8'h11; reg_wr_en = 1;
        byte_addr = 8'h03; byte_wr_data = 8'h22; byte_wr_en = 1; tick();
        rbyte("R9 byte over reg", 8'h03, 8'h22);

        // R10 bank taken before the edge
        byte_addr = 8'hD0; byte_wr_data = 8'h08; byte_wr_en = 1;
        reg_num = 3'd1; reg_wr_data = 8'h66; reg_wr_en = 1; tick();
        rbyte("R10 old bank 01", 8'h01, 8'h66);
        rbyte("R10 new bank 09", 8'h09, 8'h00);
        chk("R10 bank1", {6'b0, bank_sel}, 8'h01);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule